// File: doc/BRIEF.md
# Multi-Mode Trace Capture Buffer

This block records processor bus activity into a circular store once tracing has been triggered elsewhere. Each clock the caller presents one classified cycle: a cycle kind, the program counter, the bus address and the bus data. A two-bit mode input picks which cycles are kept. Three of the modes keep program counter values: every change of flow, every change of flow except an immediate repeat of the previous source address, or every executed program counter. The fourth mode keeps address and data pairs for real bus transfers only.

Software drains the store through a 16-bit read window. Every read strobe consumes one word, and each stored entry is exactly two words long. When the store is full, new entries overwrite the oldest unread ones. No cycle is stored while the secure flag is high or while tracing is off. An output reports how many whole entries are waiting to be read.

Top module: `trace_capture_buffer`

## Requirements
- R1: After reset, `entryCount` is 0 and `rdData` is 0.
- R2: In mode 0 (`traceMode`=0), an entry `{pc, 16'h0000}` is stored only for cycle kind 5 (change of flow, `cycKind`=5). Kinds 0 (none), 1 (free), 2 (opcode fetch), 3 (read), 4 (write) and 6 (executed instruction) store nothing.
- R3: Mode 1 stores like mode 0. The exception is a kind-5 cycle whose `pc` equals the source of the most recent stored kind-5 entry: that cycle is dropped. The memory of the last source is cleared in any cycle where `traceEn` is low.
- R4: Mode 2 stores `{addr, data}` for kinds 3 and 4 only. Free cycles, opcode fetches and kinds 0, 5 and 6 are not stored.
- R5: Mode 3 stores `{pc, 16'h0000}` for every kind-5 and kind-6 cycle.
- R6: No cycle is stored while `secure` is high or `traceEn` is low, whatever the mode and kind.
- R7: Entries are read oldest first. `rdData` shows the upper word (pc or address) of the oldest entry. A strobe on `rdReq` moves it to the lower word (zero or data). A second strobe retires the entry and decrements `entryCount`.
- R8: With no entries, `rdData` is 0, and a strobe on `rdReq` changes neither `rdData` nor `entryCount`.
- R9: `entryCount` tracks stored, unretired entries and saturates at 64. A store into a full buffer discards the oldest entry, and the read position restarts at the upper word of the new oldest entry.
- R10: A store and the retiring read of an entry in the same cycle leave `entryCount` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| traceEn | input | 1 | Tracing triggered and running |
| secure | input | 1 | System secured; blocks all storage |
| traceMode | input | 2 | 0 flow, 1 flow without repeats, 2 bus detail, 3 every PC |
| cycKind | input | 3 | Cycle classification, codes 0..6 as in the requirements |
| pc | input | 16 | Program counter, or source address of a change of flow |
| addr | input | 16 | Bus address |
| data | input | 16 | Bus data |
| rdReq | input | 1 | Read strobe for the window; consumes one word |
| rdData | output | 16 | Current window word |
| entryCount | output | 7 | Number of whole entries waiting |

## Verification
The bound checker checks a set of properties on every cycle. The count never exceeds 64 and moves by at most one per cycle. Secure cycles, disabled tracing, free cycles and opcode fetches never raise the count. In bus-detail mode, flow events are never stored. An empty buffer reads zero and stays empty under reads. Only the bench scenarios can show data content and ordering. These cover the stored words per mode, the suppression of repeated sources, the oldest-first word order, and which entries survive an overflow.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

  typedef enum logic [1:0] {
    MODE_FLOW    = 2'd0,
    MODE_NOREP   = 2'd1,
    MODE_BUS     = 2'd2,
    MODE_EVERYPC = 2'd3
  } trace_mode_e;

  typedef enum logic [2:0] {
    CYC_NONE  = 3'd0,
    CYC_FREE  = 3'd1,
    CYC_FETCH = 3'd2,
    CYC_READ  = 3'd3,
    CYC_WRITE = 3'd4,
    CYC_FLOW  = 3'd5,
    CYC_STEP  = 3'd6
  } cyc_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;       // write one entry at wrPtr
    logic busEntry;   // entry is {addr,data} rather than {pc,0}
    logic loadLast;   // remember pc as last stored flow source
    logic clearLast;  // forget last flow source
    logic showLow;    // window shows lower word of oldest entry
    logic isEmpty;    // nothing to read: window shows zero
  } tcb_strobe_t;

endpackage

// File: rtl/tcb_ctrl.sv
module tcb_ctrl
  import tcb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          traceEn,
  input  logic          secure,
  input  logic [1:0]    traceMode,
  input  logic [2:0]    cycKind,
  input  logic          rdReq,
  input  logic          srcRepeat,
  output tcb_strobe_t   strobe,
  output logic [PW-1:0] wrPtr,
  output logic [PW-1:0] rdPtr,
  output logic [CW-1:0] entryCount
);

  localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

  function automatic logic [PW-1:0] bumpPtr(input logic [PW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  trace_mode_e modeSel;
  cyc_kind_e   kindSel;
  logic        wantStore;
  logic        isFlow;
  logic        isBus;
  logic        halfSel;
  logic        emptyNow;
  logic        fullNow;
  logic        readDone;
  logic        readFirst;
  logic        dropOld;

  assign modeSel  = trace_mode_e'(traceMode);
  assign kindSel  = cyc_kind_e'(cycKind);
  assign isFlow   = (kindSel == CYC_FLOW);
  assign isBus    = (kindSel == CYC_READ) || (kindSel == CYC_WRITE);
  assign emptyNow = (entryCount == '0);
  assign fullNow  = (entryCount == FULL_CNT);

  always_comb begin
    wantStore = 1'b0;
    unique case (modeSel)
      MODE_FLOW:    wantStore = isFlow;
      MODE_NOREP:   wantStore = isFlow && !srcRepeat;
      MODE_BUS:     wantStore = isBus;
      MODE_EVERYPC: wantStore = isFlow || (kindSel == CYC_STEP);
      default:      wantStore = 1'b0;
    endcase
  end

  always_comb begin
    strobe.wrEn      = traceEn && !secure && wantStore;
    strobe.busEntry  = (modeSel == MODE_BUS);
    strobe.loadLast  = strobe.wrEn && isFlow;
    strobe.clearLast = !traceEn;
    strobe.showLow   = halfSel;
    strobe.isEmpty   = emptyNow;
  end

  assign readFirst = rdReq && !emptyNow && !halfSel;
  assign readDone  = rdReq && !emptyNow && halfSel;
  assign dropOld   = strobe.wrEn && fullNow && !readDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      halfSel    <= 1'b0;
      entryCount <= '0;
    end else begin
      if (strobe.wrEn) wrPtr <= bumpPtr(wrPtr);
      if (readDone || dropOld) begin
        rdPtr   <= bumpPtr(rdPtr);
        halfSel <= 1'b0;
      end else if (readFirst) begin
        halfSel <= 1'b1;
      end
      if (strobe.wrEn && !fullNow && !readDone)
        entryCount <= entryCount + 1'b1;
      else if (!strobe.wrEn && readDone)
        entryCount <= entryCount - 1'b1;
    end
  end

endmodule

// File: rtl/tcb_store.sv
module tcb_store
  import tcb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16,
  parameter int PW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tcb_strobe_t       strobe,
  input  logic [PW-1:0]     wrPtr,
  input  logic [PW-1:0]     rdPtr,
  input  logic [WORD_W-1:0] pc,
  input  logic [WORD_W-1:0] addr,
  input  logic [WORD_W-1:0] data,
  output logic              srcRepeat,
  output logic [WORD_W-1:0] rdData
);

  localparam int ENTRY_W = 2 * WORD_W;

  logic [ENTRY_W-1:0] slots [DEPTH];
  logic [ENTRY_W-1:0] newEntry;
  logic [ENTRY_W-1:0] oldest;
  logic [WORD_W-1:0]  lastSrc;
  logic               lastValid;

  assign newEntry = strobe.busEntry ? {addr, data} : {pc, {WORD_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (strobe.wrEn) slots[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastSrc   <= '0;
      lastValid <= 1'b0;
    end else if (strobe.clearLast) begin
      lastValid <= 1'b0;
    end else if (strobe.loadLast) begin
      lastSrc   <= pc;
      lastValid <= 1'b1;
    end
  end

  assign srcRepeat = lastValid && (pc == lastSrc);

  assign oldest = slots[rdPtr];
  assign rdData = strobe.isEmpty ? '0 :
                  strobe.showLow ? oldest[WORD_W-1:0] : oldest[ENTRY_W-1:WORD_W];

endmodule

// File: rtl/trace_capture_buffer.sv
module trace_capture_buffer
  import tcb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       traceEn,
  input  logic                       secure,
  input  logic [1:0]                 traceMode,
  input  logic [2:0]                 cycKind,
  input  logic [WORD_W-1:0]          pc,
  input  logic [WORD_W-1:0]          addr,
  input  logic [WORD_W-1:0]          data,
  input  logic                       rdReq,
  output logic [WORD_W-1:0]          rdData,
  output logic [$clog2(DEPTH+1)-1:0] entryCount
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  tcb_strobe_t   strobe;
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic          srcRepeat;

  tcb_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .traceEn    (traceEn),
    .secure     (secure),
    .traceMode  (traceMode),
    .cycKind    (cycKind),
    .rdReq      (rdReq),
    .srcRepeat  (srcRepeat),
    .strobe     (strobe),
    .wrPtr      (wrPtr),
    .rdPtr      (rdPtr),
    .entryCount (entryCount)
  );

  tcb_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .PW(PW)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .pc        (pc),
    .addr      (addr),
    .data      (data),
    .srcRepeat (srcRepeat),
    .rdData    (rdData)
  );

endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              traceEn,
  input logic              secure,
  input logic [1:0]        traceMode,
  input logic [2:0]        cycKind,
  input logic              rdReq,
  input logic [WORD_W-1:0] rdData,
  input logic [CW-1:0]     entryCount
);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    entryCount <= CW'(DEPTH)); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (entryCount <= $past(entryCount) + 1'b1) && (entryCount + 1'b1 >= $past(entryCount))); // R10

  AST_SECURE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
    secure |=> entryCount <= $past(entryCount)); // R6

  AST_IDLE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
    !traceEn |=> entryCount <= $past(entryCount)); // R6

  AST_FREE_FETCH_SKIPPED: assert property (@(posedge clk) disable iff (!rstN)
    (cycKind == 3'd1 || cycKind == 3'd2) |=> entryCount <= $past(entryCount)); // R4

  AST_BUS_MODE_SKIPS_FLOW: assert property (@(posedge clk) disable iff (!rstN)
    (traceMode == 2'd2 && cycKind == 3'd5) |=> entryCount <= $past(entryCount)); // R4

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    entryCount == '0 |-> rdData == '0); // R8

  AST_EMPTY_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (entryCount == '0 && rdReq && !traceEn) |=> entryCount == '0); // R8

endmodule

bind trace_capture_buffer tcb_checker #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_tcb_checker (
  .clk        (clk),
  .rstN       (rstN),
  .traceEn    (traceEn),
  .secure     (secure),
  .traceMode  (traceMode),
  .cycKind    (cycKind),
  .rdReq      (rdReq),
  .rdData     (rdData),
  .entryCount (entryCount)
);

// File: tb/trace_capture_buffer_test.sv
module trace_capture_buffer_test;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        traceEn = 1'b0;
  logic        secure = 1'b0;
  logic [1:0]  traceMode = 2'd0;
  logic [2:0]  cycKind = 3'd0;
  logic [15:0] pc = '0;
  logic [15:0] addr = '0;
  logic [15:0] data = '0;
  logic        rdReq = 1'b0;
  logic [15:0] rdData;
  logic [6:0]  entryCount;

  int tests = 0;
  int fails = 0;
  logic [31:0] model[$];
  bit          rdHalf = 1'b0;
  bit          lastOk = 1'b0;
  logic [15:0] lastSrc = '0;
  bit          done = 1'b0;

  trace_capture_buffer uut (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .secure(secure),
    .traceMode(traceMode), .cycKind(cycKind), .pc(pc), .addr(addr),
    .data(data), .rdReq(rdReq), .rdData(rdData), .entryCount(entryCount)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit keeps(input logic [1:0] m, input logic [2:0] k, input logic [15:0] p);
    if (!traceEn || secure) return 1'b0;
    case (m)
      2'd0: return k == 3'd5;
      2'd1: return (k == 3'd5) && !(lastOk && p == lastSrc);
      2'd2: return (k == 3'd3) || (k == 3'd4);
      default: return (k == 3'd5) || (k == 3'd6);
    endcase
  endfunction

  // one clock: optional read strobe and one classified cycle; checks window first
  task automatic cycleOp(input string req, input logic [2:0] k, input logic [15:0] p,
                         input logic [15:0] a, input logic [15:0] d, input bit rd);
    logic [15:0] expWord;
    bit st;
    expWord = (model.size() == 0) ? 16'h0 : (rdHalf ? model[0][15:0] : model[0][31:16]);
    if (rd) check(req, {16'h0, rdData}, {16'h0, expWord});
    st = keeps(traceMode, k, p);
    cycKind = k; pc = p; addr = a; data = d; rdReq = rd;
    @(negedge clk);
    cycKind = 3'd0; rdReq = 1'b0;
    if (rd && model.size() != 0) begin
      if (rdHalf) begin void'(model.pop_front()); rdHalf = 1'b0; end
      else rdHalf = 1'b1;
    end
    if (st) begin
      if (model.size() == DEPTH) begin void'(model.pop_front()); rdHalf = 1'b0; end
      model.push_back((traceMode == 2'd2) ? {a, d} : {p, 16'h0});
      if (k == 3'd5) begin lastSrc = p; lastOk = 1'b1; end
    end
    if (!traceEn) lastOk = 1'b0;
    check(req, {25'h0, entryCount}, model.size());
  endtask

  task automatic drain(input string req);
    while (model.size() != 0) cycleOp(req, 3'd0, 16'h0, 16'h0, 16'h0, 1'b1);
    check(req, {16'h0, rdData}, 32'h0);
  endtask

  task automatic pauseTrace();
    traceEn = 1'b0;
    cycleOp("R6", 3'd0, 16'h0, 16'h0, 16'h0, 1'b0);
    traceEn = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {25'h0, entryCount}, 0);
    check("R1", {16'h0, rdData}, 0);

    // R8: reads on an empty buffer
    for (int i = 0; i < 3; i++) cycleOp("R8", 3'd0, 16'h0, 16'h0, 16'h0, 1'b1);

    traceEn = 1'b1;
    // R2: mode 0 sweep of every kind
    traceMode = 2'd0;
    for (int k = 0; k < 7; k++) cycleOp("R2", 3'(k), 16'h1000 + 16'(k), 16'hA000 + 16'(k), 16'hD000 + 16'(k), 1'b0);
    drain("R7");

    // R5: every-PC sweep
    pauseTrace();
    traceMode = 2'd3;
    for (int k = 0; k < 7; k++) cycleOp("R5", 3'(k), 16'h3000 + 16'(k), 16'hA100 + 16'(k), 16'hD100 + 16'(k), 1'b0);
    drain("R7");

    // R4: bus detail sweep, two passes
    traceMode = 2'd2;
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 7; k++)
        cycleOp("R4", 3'(k), 16'h4000 + 16'(k), 16'h2000 + 16'(k + 8 * r), 16'hC000 + 16'(k + 8 * r), 1'b0);
    drain("R7");

    // R3: repeated flow sources suppressed
    pauseTrace();
    traceMode = 2'd1;
    cycleOp("R3", 3'd5, 16'h5555, 16'h0, 16'h0, 1'b0);
    cycleOp("R3", 3'd5, 16'h5555, 16'h0, 16'h0, 1'b0);
    cycleOp("R3", 3'd6, 16'h1234, 16'h0, 16'h0, 1'b0);
    cycleOp("R3", 3'd5, 16'h5555, 16'h0, 16'h0, 1'b0);
    cycleOp("R3", 3'd5, 16'h6666, 16'h0, 16'h0, 1'b0);
    cycleOp("R3", 3'd5, 16'h5555, 16'h0, 16'h0, 1'b0);
    cycleOp("R3", 3'd5, 16'h5555, 16'h0, 16'h0, 1'b0);
    check("R3", {25'h0, entryCount}, 3);
    pauseTrace();
    cycleOp("R3", 3'd5, 16'h5555, 16'h0, 16'h0, 1'b0);
    check("R3", {25'h0, entryCount}, 4);
    drain("R7");

    // R6: secure and disabled block every kind in every mode
    for (int m = 0; m < 4; m++) begin
      traceMode = 2'(m);
      secure = 1'b1;
      for (int k = 0; k < 7; k++) cycleOp("R6", 3'(k), 16'h7000 + 16'(k), 16'h7100, 16'h7200, 1'b0);
      secure = 1'b0;
      traceEn = 1'b0;
      for (int k = 0; k < 7; k++) cycleOp("R6", 3'(k), 16'h7300 + 16'(k), 16'h7400, 16'h7500, 1'b0);
      traceEn = 1'b1;
    end
    check("R6", {25'h0, entryCount}, 0);

    // R9: overflow, oldest discarded, mid-entry read restarts
    traceMode = 2'd3;
    for (int i = 0; i < 70; i++) begin
      cycleOp("R9", 3'd6, 16'h0100 + 16'(i), 16'h0, 16'h0, 1'b0);
      if (i == 66) cycleOp("R9", 3'd0, 16'h0, 16'h0, 16'h0, 1'b1);
    end
    check("R9", {25'h0, entryCount}, DEPTH);
    drain("R9");

    // R10: store coinciding with retiring read
    traceMode = 2'd0;
    for (int i = 0; i < 3; i++) cycleOp("R10", 3'd5, 16'h0900 + 16'(i), 16'h0, 16'h0, 1'b0);
    cycleOp("R10", 3'd0, 16'h0, 16'h0, 16'h0, 1'b1);
    cycleOp("R10", 3'd5, 16'h0999, 16'h0, 16'h0, 1'b1);
    check("R10", {25'h0, entryCount}, 3);
    traceMode = 2'd3;
    for (int i = 0; i < 61; i++) cycleOp("R10", 3'd6, 16'h0A00 + 16'(i), 16'h0, 16'h0, 1'b0);
    cycleOp("R10", 3'd0, 16'h0, 16'h0, 16'h0, 1'b1);
    cycleOp("R10", 3'd6, 16'h0BBB, 16'h0, 16'h0, 1'b1);
    check("R10", {25'h0, entryCount}, DEPTH);
    drain("R10");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule